// File: doc/BRIEF.md
# XOR-Gated Run/Stop Binary Counter

This block is a binary up-counter whose run/stop decision is taken from a pair of synchronous enable inputs compared with each other: when the two agree (both low or both high) the counter advances, and when they disagree it freezes. The decision is sampled at the same clock edge that would advance the count, so a stop request that lands on an edge takes hold at that edge. An asynchronous start input overrides a stop. It latches a start request the moment it rises, so even a pulse that comes and goes between two clock edges grants the next edge. An asynchronous master reset clears the count at once and outranks every enable.

The count is presented on a true bus and on a complemented bus. A typical use is a programmable clock-division or interval-measurement stage. Two independent control sources can each veto counting, and a third can force it to run. Inputs left tied low give a free-running counter.

Top module: `xen_counter`

## Requirements
- R1: While `rst` is high, `count_q` is 0, from the moment `rst` rises and without waiting for a clock edge, regardless of `en_a`, `en_b` and `start_async`.
- R2: With `start_async` low, no start pending, and `en_a` equal to `en_b` (both 0 or both 1), `count_q` increases by exactly 1 at each rising edge of `clk`.
- R3: With no start pending and `en_a` different from `en_b` at a rising edge, `count_q` does not change at that edge; the stop takes effect at the edge that samples the mismatch.
- R4: While stopped, `count_q` keeps its value over any number of clock edges until counting is re-enabled.
- R5: While `start_async` is high at a rising edge, `count_q` increases by 1 at that edge whatever `en_a` and `en_b` are.
- R6: A `start_async` pulse that rises and falls between two rising edges does not change `count_q` by itself, grants exactly one increment at the next rising edge, and leaves later edges to the enable pair.
- R7: After the all-ones value (255 at the default width) the next increment gives 0.
- R8: `count_n` is always the bitwise complement of `count_q`.
- R9: After `rst` falls, the first rising edge of `clk` advances the count only if the enable logic permits it at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock, rising edge active |
| rst | input | 1 | Asynchronous master reset, active high |
| en_a | input | 1 | First synchronous enable of the compared pair |
| en_b | input | 1 | Second synchronous enable of the compared pair |
| start_async | input | 1 | Asynchronous start, active high, overrides a stop |
| count_q | output | WIDTH (8) | Count value |
| count_n | output | WIDTH (8) | Bitwise complement of the count |

## Verification
The enable pair is driven through all four combinations. Both agreeing settings must advance, which shows the decision is an equality test and not a plain AND or OR. Both disagreeing settings must freeze on the very edge that samples them, which separates same-edge sampling from a one-cycle-late enable. A held start level, a start pulse confined between edges, and a reset asserted mid-cycle during counting tell the override's latching and the priorities apart. A run through the all-ones value checks the wrap.

// File: rtl/xen_pkg.sv
package xen_pkg;

  localparam int XEN_WIDTH_DEF = 8;

  // Run decision for one clock edge: a pending start wins, otherwise the
  // enable pair must agree (equality, i.e. inverted exclusive-OR).
  function automatic logic xen_run(input logic a, input logic b, input logic pend);
    logic agree;
    agree = (a == b);
    return pend | agree;
  endfunction

endpackage

// File: rtl/xen_gate.sv
module xen_gate
  import xen_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_a,
  input  logic en_b,
  input  logic start_async,
  output logic run_now,
  output logic pend_q
);

  // Start request flop: set asynchronously by the start input, dropped at
  // the first clock edge that sees the start input low again.
  always_ff @(posedge clk or posedge rst or posedge start_async) begin
    if (rst)
      pend_q <= 1'b0;
    else if (start_async)
      pend_q <= 1'b1;
    else
      pend_q <= 1'b0;
  end

  assign run_now = xen_run(en_a, en_b, pend_q);

  // R5: a start level seen at the edge always lets the counter advance
  p_start_forces_r5: assert property (@(posedge clk) disable iff (rst)
    start_async |-> run_now);

  // R6: a start latched between edges grants the coming edge
  p_pending_grants_r6: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> run_now);

  // R3: disagreeing enables without a start block the edge
  p_mismatch_stops_r3: assert property (@(posedge clk) disable iff (rst)
    ((en_a != en_b) && !pend_q && !start_async) |-> !run_now);

  // R2: agreeing enables always permit the edge
  p_match_runs_r2: assert property (@(posedge clk) disable iff (rst)
    (en_a == en_b) |-> run_now);

endmodule

// File: rtl/xen_count.sv
module xen_count #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [WIDTH-1:0] cnt_q
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  // Arithmetic view of one step, used by the checks below.
  function automatic logic [WIDTH-1:0] xen_step(input logic [WIDTH-1:0] v);
    return v + WIDTH'(1);
  endfunction

  // Toggle chain: bit i flips when the step is permitted and every lower
  // bit is one, as in a ripple stage fed by its neighbour.
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] flip;

  assign carry[0] = adv;
  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    assign carry[i+1] = carry[i] & cnt_q[i];
    assign flip[i]    = carry[i];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q ^ flip;
  end

  // R1: reset holds the count at zero
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |-> (cnt_q == '0));

  // R2: a permitted edge advances by one
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    adv |=> (cnt_q == xen_step($past(cnt_q))));

  // R4: a blocked edge keeps the value
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> (cnt_q == $past(cnt_q)));

  // R7: all ones wraps to zero
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (adv && (cnt_q == ALL_ONES)) |=> (cnt_q == '0));

endmodule

// File: rtl/xen_drive.sv
module xen_drive #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] out_t,
  output logic [WIDTH-1:0] out_c
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pair
    assign out_t[i] = cnt[i];
    assign out_c[i] = ~cnt[i];
  end

  // R8: each true/complement pair differs in every bit
  always_comb begin
    a_pair_r8: assert ((out_t ^ out_c) == {WIDTH{1'b1}} || $isunknown(cnt));
  end

endmodule

// File: rtl/xen_counter.sv
module xen_counter
  import xen_pkg::*;
#(
  parameter int WIDTH = XEN_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_a,
  input  logic             en_b,
  input  logic             start_async,
  output logic [WIDTH-1:0] count_q,
  output logic [WIDTH-1:0] count_n
);

  logic             run_now;
  logic             pend_q;
  logic [WIDTH-1:0] cnt;

  xen_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .en_a        (en_a),
    .en_b        (en_b),
    .start_async (start_async),
    .run_now     (run_now),
    .pend_q      (pend_q)
  );

  xen_count #(.WIDTH(WIDTH)) u_count (
    .clk   (clk),
    .rst   (rst),
    .adv   (run_now),
    .cnt_q (cnt)
  );

  xen_drive #(.WIDTH(WIDTH)) u_drive (
    .cnt   (cnt),
    .out_t (count_q),
    .out_c (count_n)
  );

  // R9: the first edge after reset release follows the enable logic
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !run_now) |=> (count_q == '0));

endmodule

// File: tb/xen_counter_bench.sv
module xen_counter_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en_a = 1'b0;
  logic         en_b = 1'b0;
  logic         start_async = 1'b0;
  logic [W-1:0] count_q;
  logic [W-1:0] count_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  xen_counter #(.WIDTH(W)) u_xen_counter (
    .clk         (clk),
    .rst         (rst),
    .en_a        (en_a),
    .en_b        (en_b),
    .start_async (start_async),
    .count_q     (count_q),
    .count_n     (count_n)
  );

  task automatic chk(input string req, input logic [W-1:0] exp_v);
    checks++;
    if (count_q !== exp_v) begin
      errors++;
      $display("FAIL %s: count got %0d expected %0d", req, count_q, exp_v);
    end
    checks++;
    if (count_n !== ~exp_v) begin
      errors++;
      $display("FAIL R8 (%s): complement got %0h expected %0h", req, count_n, ~exp_v);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    rst = 1'b1; en_a = 1'b0; en_b = 1'b0; start_async = 1'b0;
    edges(2);
    chk("R1 reset state", 8'd0);
  endtask

  task automatic t_release_low_pair();
    @(negedge clk);
    rst = 1'b0; en_a = 1'b0; en_b = 1'b0;
    edges(1);
    chk("R9 first edge after release counts", 8'd1);
    edges(4);
    chk("R2 both low runs", 8'd5);
  endtask

  task automatic t_high_pair();
    en_a = 1'b1; en_b = 1'b1;
    edges(3);
    chk("R2 both high runs", 8'd8);
  endtask

  task automatic t_one_side();
    en_a = 1'b1; en_b = 1'b0;
    edges(1);
    chk("R3 stop at sampling edge (1,0)", 8'd8);
    edges(5);
    chk("R4 hold while stopped", 8'd8);
    en_a = 1'b0; en_b = 1'b1;
    edges(3);
    chk("R3 stop with (0,1)", 8'd8);
    en_a = 1'b1; en_b = 1'b1;
    edges(1);
    chk("R2 resume on agreement", 8'd9);
  endtask

  task automatic t_start_level();
    en_a = 1'b1; en_b = 1'b0; start_async = 1'b1;
    edges(3);
    chk("R5 start level overrides stop", 8'd12);
    start_async = 1'b0;
    edges(1);
    chk("R6 start dropped before edge still grants one", 8'd13);
    edges(2);
    chk("R3 stop returns after start", 8'd13);
  endtask

  task automatic t_start_pulse();
    en_a = 1'b0; en_b = 1'b1;
    #5 start_async = 1'b1;
    #3 start_async = 1'b0;
    chk("R6 pulse alone leaves count", 8'd13);
    @(negedge clk);
    chk("R6 pulse grants next edge", 8'd14);
    edges(3);
    chk("R6 later edges follow enables", 8'd14);
  endtask

  task automatic t_reset_running();
    en_a = 1'b0; en_b = 1'b0;
    edges(3);
    chk("R2 running before reset", 8'd17);
    #4 rst = 1'b1; start_async = 1'b1;
    #1 chk("R1 reset clears without edge", 8'd0);
    @(negedge clk);
    chk("R1 reset outranks start", 8'd0);
    start_async = 1'b0; en_a = 1'b1; en_b = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    edges(1);
    chk("R9 blocked first edge after release", 8'd0);
    en_a = 1'b0;
    edges(1);
    chk("R9 counts once permitted", 8'd1);
  endtask

  task automatic t_wrap();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; en_a = 1'b1; en_b = 1'b1;
    edges(255);
    chk("R7 reach all ones", 8'd255);
    edges(1);
    chk("R7 wrap to zero", 8'd0);
    edges(1);
    chk("R7 continue after wrap", 8'd1);
  endtask

  initial begin
    t_reset_state();
    t_release_low_pair();
    t_high_pair();
    t_one_side();
    t_start_level();
    t_start_pulse();
    t_reset_running();
    t_wrap();
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule